// File: doc/BRIEF.md
# Cascaded Decade Programmable Divider

The block divides an input clock by a three-digit decimal divisor N. N is given as binary-coded decimal, and the block produces one output pulse, one clock wide, every N input clocks. Inside are three single-digit decade down-counters for units, tens and hundreds. The units digit steps on every clock. Each more significant digit steps only when every digit below it is at zero, so the borrow ripples up the chain.

When the count reaches one, the next clock does not step. It reloads all three digits from the divisor input and raises the output pulse for that cycle. The reload replaces the step, so each period is exactly N clocks long. The divisor is read only at a reload. A new value therefore takes effect at the next reload, and the period already running finishes with the old value.

A divisor of zero keeps the output low. A divisor of one gives a pulse on every clock. After reset the count is zero, and the block treats a zero count as a reload point. The first pulse therefore comes on the first clock after reset is released.

Top module: `decade_divider`

## Requirements
- R1: While rstN is low, pulseOut is low and all count digits are cleared to zero.
- R2: The count goes down by one in decimal on every clock. A digit at 0 wraps to 9 and takes one from the next higher digit, so divisors that cross tens and hundreds boundaries (10, 99, 100, 999) give exact periods.
- R3: For any divisor N from 2 to 999, pulseOut is high for exactly one clock in every N clocks.
- R4: With N = 1, pulseOut is high on every clock.
- R5: With N = 0, pulseOut stays low. Once a nonzero N is applied while the block is idle at zero, the first pulse comes one clock later.
- R6: A change of divisorBcd does not alter the period in progress. The new value sets the length of the next period.
- R7: With a nonzero divisor, the first pulse after reset release is asserted at the first rising clock edge with rstN high.
- R8: divisorBcd holds the hundreds digit in bits [11:8], the tens digit in bits [7:4] and the units digit in bits [3:0]. Given valid digits (0 to 9), every count digit stays in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Active-low synchronous reset |
| divisorBcd | input | 12 | Divisor N as three BCD digits: hundreds, tens, units |
| pulseOut | output | 1 | One-clock-wide high pulse, once per N clocks |

## Verification
The assertions assume that every digit of divisorBcd is a legal decimal digit (0 to 9). They also assume that the divisor seen at a reload edge is the one the following period is meant to use. The stimulus writes the divisor only through a helper that encodes integers 0 to 999 digit by digit, so no code from 10 to 15 ever appears in any field. The divisor is changed only on falling edges, which keeps every reload edge free of a value in transition.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // reload every digit from the divisor
    logic count;  // step enable into the units digit
  } divStrobe_t;
endpackage

// File: rtl/decade_stage.sv
module decade_stage #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepIn,
  input  logic               loadEn,
  input  logic [DIGIT_W-1:0] loadVal,
  output logic [DIGIT_W-1:0] digit,
  output logic               isZero
);
  localparam logic [DIGIT_W-1:0] TOP_DIGIT = DIGIT_W'(9);

  assign isZero = (digit == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      digit <= '0;
    end else if (loadEn) begin
      digit <= loadVal;
    end else if (stepIn) begin
      digit <= isZero ? TOP_DIGIT : digit - DIGIT_W'(1);
    end
  end
endmodule

// File: rtl/decdiv_datapath.sv
module decdiv_datapath
  import decdiv_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  divStrobe_t                    strobe,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] divisor,
  output logic [NUM_DIGITS*DIGIT_W-1:0] countVal,
  output logic                          atOne,
  output logic                          atZero,
  output logic                          divisorZero
);
  localparam int TOT_W = NUM_DIGITS * DIGIT_W;

  logic [NUM_DIGITS-1:0] digitZero;
  logic [NUM_DIGITS-1:0] borrow;

  assign borrow[0] = strobe.count;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    decade_stage #(.DIGIT_W(DIGIT_W)) u_stage (
      .clk     (clk),
      .rstN    (rstN),
      .stepIn  (borrow[i]),
      .loadEn  (strobe.load),
      .loadVal (divisor[i*DIGIT_W +: DIGIT_W]),
      .digit   (countVal[i*DIGIT_W +: DIGIT_W]),
      .isZero  (digitZero[i])
    );
    if (i < NUM_DIGITS - 1) begin : g_chain
      // next digit steps only when all lower digits sit at zero
      assign borrow[i+1] = borrow[i] & digitZero[i];
    end
  end

  assign atZero      = &digitZero;
  assign atOne       = (&digitZero[NUM_DIGITS-1:1]) &&
                       (countVal[DIGIT_W-1:0] == DIGIT_W'(1));
  assign divisorZero = (divisor == TOT_W'(0));
endmodule

// File: rtl/decdiv_control.sv
module decdiv_control
  import decdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       atOne,
  input  logic       atZero,
  input  logic       divisorZero,
  output divStrobe_t strobe,
  output logic       pulse
);
  always_comb begin
    strobe.count = 1'b1;
    strobe.load  = atOne | atZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulse <= 1'b0;
    end else begin
      pulse <= strobe.load & ~divisorZero;
    end
  end
endmodule

// File: rtl/decade_divider.sv
module decade_divider
  import decdiv_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] divisorBcd,
  output logic                          pulseOut
);
  localparam int TOT_W = NUM_DIGITS * DIGIT_W;

  divStrobe_t       strobe;
  logic [TOT_W-1:0] countBcd;
  logic             atOne;
  logic             atZero;
  logic             divisorZero;

  decdiv_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .atOne       (atOne),
    .atZero      (atZero),
    .divisorZero (divisorZero),
    .strobe      (strobe),
    .pulse       (pulseOut)
  );

  decdiv_datapath #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .divisor     (divisorBcd),
    .countVal    (countBcd),
    .atOne       (atOne),
    .atZero      (atZero),
    .divisorZero (divisorZero)
  );
endmodule

// File: rtl/decdiv_checker.sv
module decdiv_checker #(
  parameter int NUM_DIGITS = 3,
  parameter int DIGIT_W    = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_DIGITS*DIGIT_W-1:0] divisorBcd,
  input logic [NUM_DIGITS*DIGIT_W-1:0] countBcd,
  input logic                          pulseOut
);
  localparam int TOT_W = NUM_DIGITS * DIGIT_W;
  localparam logic [TOT_W-1:0] ONE_VAL = TOT_W'(1);

  // R5
  zero_divisor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divisorBcd == '0) |=> !pulseOut);

  // R6
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> (countBcd == $past(divisorBcd)));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((countBcd != '0) && (countBcd != ONE_VAL)) |=> !pulseOut);

  // R4
  every_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((countBcd == ONE_VAL) && (divisorBcd == ONE_VAL)) |=> pulseOut);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!pulseOut && (countBcd == '0)));

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_rng
    // R8
    digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      countBcd[i*DIGIT_W +: DIGIT_W] <= DIGIT_W'(9));
  end
endmodule

bind decade_divider decdiv_checker #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .divisorBcd (divisorBcd),
  .countBcd   (countBcd),
  .pulseOut   (pulseOut)
);

// File: tb/decade_divider_bench.sv
module decade_divider_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] divisorBcd = '0;
  logic        pulseOut;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  decade_divider u_decade_divider (
    .clk        (clk),
    .rstN       (rstN),
    .divisorBcd (divisorBcd),
    .pulseOut   (pulseOut)
  );

  function automatic logic [11:0] toBcd(int v);
    return {4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until pulseOut is seen high
  task automatic nextPulse(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!pulseOut && gap < 2000);
  endtask

  int curN;

  // switch divisor just after a pulse, then measure periods
  task automatic runDivisor(int n, string req);
    int gap;
    divisorBcd = toBcd(n);
    nextPulse(gap);
    check(gap == curN, "R6 old period completes", gap, curN);
    for (int k = 0; k < 3; k++) begin
      nextPulse(gap);
      check(gap == n, req, gap, n);
    end
    curN = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap;
    int seen;
    divisorBcd = toBcd(5);
    repeat (3) begin
      @(negedge clk);
      check(pulseOut == 1'b0, "R1 low in reset", pulseOut, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(pulseOut == 1'b1, "R7 first pulse after reset", pulseOut, 1);
    for (int k = 0; k < 2; k++) begin
      nextPulse(gap);
      check(gap == 5, "R3 period after reset", gap, 5);
    end
    curN = 5;

    // near-exhaustive sweep of small divisors
    for (int n = 1; n <= 40; n++) begin
      runDivisor(n, n == 1 ? "R4 every clock" : "R3 period");
    end
    runDivisor(9, "R3 period nine");
    runDivisor(10, "R2 tens borrow");
    runDivisor(99, "R2 wrap below hundred");
    runDivisor(100, "R2 hundreds borrow");
    runDivisor(123, "R8 digit fields");
    runDivisor(999, "R2 full range");
    runDivisor(1, "R4 every clock");
    runDivisor(2, "R3 period two");

    // R5: zero divisor silences the output
    divisorBcd = '0;
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (pulseOut) seen++;
    end
    check(seen == 0, "R5 no pulse at zero", seen, 0);
    divisorBcd = toBcd(7);
    nextPulse(gap);
    check(gap == 1, "R5 restart from zero", gap, 1);
    nextPulse(gap);
    check(gap == 7, "R5 period after restart", gap, 7);

    // R6: mid-period change
    repeat (3) @(negedge clk);
    divisorBcd = toBcd(12);
    nextPulse(gap);
    check(gap == 4, "R6 change mid period", gap, 4);
    nextPulse(gap);
    check(gap == 12, "R6 new period", gap, 12);

    // R1: reassert reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pulseOut == 1'b0, "R1 reset mid run", pulseOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pulseOut == 1'b1, "R7 pulse after second release", pulseOut, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule